// File: doc/BRIEF.md
# Pipelined Sampled-Delay Receive Beamformer

This block forms one focused receive beam from the echoes of an eight-element ultrasonic array. Each channel delivers one signed 8-bit sample per sample clock. A shared tick counter restarts at the beginning of every steering angle. Each channel has its own start threshold, and it passes samples only once the counter has reached that threshold. Before then the channel feeds zeros. Accepted samples then travel through a register chain of selectable length, so that echoes which reached different elements at different times leave their chains in the same cycle. The eight aligned samples are added, and the registered sum is the focused beam sample.

The scan controller pulses `line_start` once for every steering angle. In the same cycle it presents the eight thresholds and the eight chain depths for that angle. The pulse captures them, empties every chain and restarts the counter. The sequencer moves through three named states. `SQ_IDLE` waits for a line. `line_start` moves any state to `SQ_FILL`. `SQ_FILL` advances the counter while the chains fill, and goes to `SQ_STREAM` in the cycle the counter equals the latest arrival time. `SQ_STREAM` delivers exactly `LINE_LEN` valid sums, then returns to `SQ_IDLE`. A `line_start` in any state wins over every other transition.

Top module: `beam_align_sum`

## Requirements
- R1: While `rst_n` is low, `beam_valid` and `beam_out` are 0.
- R2: The clock edge that samples `line_start` high captures the thresholds and depths, empties every chain and sets the counter to 0. `beam_valid` is 0 in the following cycle.
- R3: Call the `line_start` edge edge 0. The counter value seen at edge k is k-1. Channel c accepts the sample presented at edge k only when k-1 is at least its threshold `thr_c`, and it contributes 0 at earlier edges. The threshold is unsigned and occupies `thr_bus[16c +: 16]`.
- R4: Channel c delays each accepted sample by `d_c` edges. Depth 0 adds no delay beyond the output register. The depth is unsigned and occupies `depth_bus[9c +: 9]`.
- R5: A depth above `MAX_DEPTH` (288) behaves exactly like `MAX_DEPTH`.
- R6: `beam_out` is the 11-bit two's-complement sum of the eight aligned samples. It is registered one edge after the samples are summed. Sample c is two's complement in `sample_bus[8c +: 8]`. Eight samples of -128 give -1024, and eight samples of +127 give +1016.
- R7: Let T be the largest value of `thr_c + d_c` over all channels, using clamped depths. `beam_valid` first goes high after edge T+1, and the sum at that edge includes every channel.
- R8: `beam_valid` stays high for exactly `LINE_LEN` (6400) cycles, then stays low until the next `line_start`.
- R9: A `line_start` during a line aborts it and restarts the sequence. This also holds when it falls on the edge where the line would have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that opens a new steering angle |
| thr_bus | input | 128 | Eight 16-bit start thresholds, channel c at bits [16c +: 16] |
| depth_bus | input | 72 | Eight 9-bit chain depths, channel c at bits [9c +: 9] |
| sample_bus | input | 64 | Eight signed 8-bit samples, channel c at bits [8c +: 8] |
| beam_out | output | 11 | Focused sum, two's complement |
| beam_valid | output | 1 | High while `beam_out` carries a sample of the current line |

## Verification
Two events can land on the same edge: the end of a line, which would send the sequencer to `SQ_IDLE`, and a new `line_start`. The bench counts exactly `T + LINE_LEN` edges after one start, then pulses the next start on the edge where `beam_valid` would fall. It then compares every following cycle against its behavioural model. That model knows nothing about the sequencer's states. The new line must begin its fill from a counter of zero, with empty chains, and its first valid sample must appear at the edge predicted from the new thresholds.

// File: rtl/bsum_pkg.sv
package bsum_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FILL   = 2'd1,
        SQ_STREAM = 2'd2
    } sq_state_e;

endpackage

// File: rtl/line_sequencer.sv
module line_sequencer
    import bsum_pkg::*;
#(
    parameter int CNTW     = 16,
    parameter int ARRW     = 17,
    parameter int LINE_LEN = 6400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic [ARRW-1:0] lim_in,
    output logic [CNTW-1:0] cnt,
    output logic [ARRW-1:0] lim_q,
    output logic            run,
    output logic            out_valid
);

    localparam int OCW = $clog2(LINE_LEN + 1);

    sq_state_e        state;
    sq_state_e        nxt;
    logic [OCW-1:0]   out_cnt;
    logic             reach;
    logic             last;
    logic [CNTW-1:0]  cnt_inc;

    assign reach   = (ARRW'(cnt) == lim_q);
    assign last    = (out_cnt == OCW'(LINE_LEN));
    assign cnt_inc = (cnt == '1) ? cnt : cnt + 1'b1;
    assign run     = (state != SQ_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (line_start) begin
            nxt = SQ_FILL;
        end else begin
            unique case (state)
                SQ_IDLE:   nxt = SQ_IDLE;
                SQ_FILL:   if (reach) nxt = SQ_STREAM;
                SQ_STREAM: if (last)  nxt = SQ_IDLE;
                default:   nxt = SQ_IDLE;
            endcase
        end
    end

    // outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            lim_q     <= '0;
            out_cnt   <= '0;
            out_valid <= 1'b0;
        end else if (line_start) begin
            cnt       <= '0;
            lim_q     <= lim_in;
            out_cnt   <= '0;
            out_valid <= 1'b0;
        end else begin
            unique case (state)
                SQ_FILL: begin
                    cnt <= cnt_inc;
                    if (reach) begin
                        out_valid <= 1'b1;
                        out_cnt   <= OCW'(1);
                    end
                end
                SQ_STREAM: begin
                    cnt <= cnt_inc;
                    if (last) out_valid <= 1'b0;
                    else      out_cnt   <= out_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/chan_tap.sv
module chan_tap #(
    parameter int SW   = 8,
    parameter int CNTW = 16,
    parameter int MAXD = 288,
    localparam int DW   = $clog2(MAXD + 1),
    localparam int ARRW = CNTW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  run,
    input  logic [CNTW-1:0]       cnt,
    input  logic [CNTW-1:0]       thr_in,
    input  logic [DW-1:0]         dep_in,
    input  logic signed [SW-1:0]  smp_in,
    output logic [ARRW-1:0]       arrival,
    output logic signed [SW-1:0]  aligned,
    output logic                  gate
);

    logic [CNTW-1:0]      thr_q;
    logic [DW-1:0]        dep_q;
    logic [DW-1:0]        dep_cl;
    logic [DW-1:0]        tap_idx;
    logic signed [SW-1:0] gated;
    logic signed [SW-1:0] chain_q [MAXD];

    assign dep_cl  = (dep_in > DW'(MAXD)) ? DW'(MAXD) : dep_in;
    assign arrival = ARRW'(thr_in) + ARRW'(dep_cl);

    assign gate    = run && (cnt >= thr_q);
    assign gated   = gate ? smp_in : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
            dep_q <= '0;
        end else if (load) begin
            thr_q <= thr_in;
            dep_q <= dep_cl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            for (int i = 0; i < MAXD; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= gated;
            for (int i = 1; i < MAXD; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign tap_idx = dep_q - 1'b1;
    assign aligned = (dep_q == '0) ? gated : chain_q[tap_idx];

endmodule

// File: rtl/lane_adder.sv
module lane_adder #(
    parameter int N  = 8,
    parameter int SW = 8,
    parameter int OW = 11
) (
    input  logic [N*SW-1:0]      terms,
    output logic signed [OW-1:0] total
);

    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + OW'($signed(terms[i*SW +: SW]));
        end
    end

endmodule

// File: rtl/beam_align_sum.sv
module beam_align_sum
    import bsum_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int SW       = 8,
    parameter int CNTW     = 16,
    parameter int MAXD     = 288,
    parameter int LINE_LEN = 6400,
    localparam int DW   = $clog2(MAXD + 1),
    localparam int ARRW = CNTW + 1,
    localparam int OW   = SW + $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic [NCH*CNTW-1:0] thr_bus,
    input  logic [NCH*DW-1:0]   depth_bus,
    input  logic [NCH*SW-1:0]   sample_bus,
    output logic [OW-1:0]       beam_out,
    output logic                beam_valid
);

    logic [CNTW-1:0]      seq_cnt;
    logic [ARRW-1:0]      lim_in;
    logic [ARRW-1:0]      lim_q;
    logic                 run;
    logic [NCH-1:0]       gate_vec;
    logic [NCH*SW-1:0]    aligned_bus;
    logic [ARRW-1:0]      arr [NCH];
    logic signed [OW-1:0] lane_sum;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic signed [SW-1:0] al;
        chan_tap #(.SW(SW), .CNTW(CNTW), .MAXD(MAXD)) u_tap (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (line_start),
            .run     (run),
            .cnt     (seq_cnt),
            .thr_in  (thr_bus[c*CNTW +: CNTW]),
            .dep_in  (depth_bus[c*DW +: DW]),
            .smp_in  ($signed(sample_bus[c*SW +: SW])),
            .arrival (arr[c]),
            .aligned (al),
            .gate    (gate_vec[c])
        );
        assign aligned_bus[c*SW +: SW] = al;
    end

    // latest arrival across the array
    always_comb begin
        lim_in = '0;
        for (int c = 0; c < NCH; c++) begin
            if (arr[c] > lim_in) lim_in = arr[c];
        end
    end

    line_sequencer #(.CNTW(CNTW), .ARRW(ARRW), .LINE_LEN(LINE_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .lim_in     (lim_in),
        .cnt        (seq_cnt),
        .lim_q      (lim_q),
        .run        (run),
        .out_valid  (beam_valid)
    );

    lane_adder #(.N(NCH), .SW(SW), .OW(OW)) u_add (
        .terms (aligned_bus),
        .total (lane_sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) beam_out <= '0;
        else        beam_out <= lane_sum;
    end

endmodule

// File: rtl/bsum_checker.sv
module bsum_checker #(
    parameter int NCH      = 8,
    parameter int CNTW     = 16,
    parameter int ARRW     = 17,
    parameter int LINE_LEN = 6400
) (
    input logic            clk,
    input logic            rst_n,
    input logic            line_start,
    input logic            beam_valid,
    input logic [NCH-1:0]  gate_vec,
    input logic [CNTW-1:0] seq_cnt,
    input logic [ARRW-1:0] lim_q
);

    localparam int VW = $clog2(LINE_LEN + 2);

    logic [VW-1:0] vrun;

    always_ff @(posedge clk) begin
        if (!rst_n)          vrun <= '0;
        else if (beam_valid) vrun <= vrun + 1'b1;
        else                 vrun <= '0;
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !beam_valid);

    p_all_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        beam_valid |-> (&gate_vec));

    p_first_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beam_valid) |-> (ARRW'(seq_cnt) == ARRW'(lim_q + 1'b1)));

    p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beam_valid |-> (vrun < VW'(LINE_LEN)));

    p_run_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(beam_valid) && !$past(line_start)) |-> (vrun == VW'(LINE_LEN)));

endmodule

bind beam_align_sum bsum_checker #(
    .NCH(NCH), .CNTW(CNTW), .ARRW(CNTW + 1), .LINE_LEN(LINE_LEN)
) u_bsum_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .beam_valid (beam_valid),
    .gate_vec   (gate_vec),
    .seq_cnt    (seq_cnt),
    .lim_q      (lim_q)
);

// File: tb/test_beam_align_sum.sv
`timescale 1ns/1ps
module test_beam_align_sum;

    localparam int NCH  = 8;
    localparam int SW   = 8;
    localparam int CNTW = 16;
    localparam int MAXD = 288;
    localparam int LLEN = 6400;
    localparam int DW   = 9;
    localparam int OW   = 11;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                line_start = 1'b0;
    logic [NCH*CNTW-1:0] thr_bus = '0;
    logic [NCH*DW-1:0]   depth_bus = '0;
    logic [NCH*SW-1:0]   sample_bus = '0;
    logic [OW-1:0]       beam_out;
    logic                beam_valid;

    beam_align_sum i_beam_align_sum (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .thr_bus(thr_bus), .depth_bus(depth_bus), .sample_bus(sample_bus),
        .beam_out(beam_out), .beam_valid(beam_valid)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    pat_mode = 0;
    bit    chk_en = 0;
    int    cyc = 0;

    int cfg_t [NCH];
    int cfg_d [NCH];

    // behavioural reference
    int hist [NCH][8192];
    int thr_m [NCH];
    int dep_m [NCH];
    int k = 0;
    int tlim = 0;
    bit active = 0;
    int exp_out = 0;
    bit exp_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            active = 0; exp_valid = 0; k = 0;
        end else if (line_start) begin
            tlim = 0;
            for (int c = 0; c < NCH; c++) begin
                thr_m[c] = int'(thr_bus[c*CNTW +: CNTW]);
                dep_m[c] = int'(depth_bus[c*DW +: DW]);
                if (dep_m[c] > MAXD) dep_m[c] = MAXD;
                if (thr_m[c] + dep_m[c] > tlim) tlim = thr_m[c] + dep_m[c];
            end
            k = 0; active = 1; exp_valid = 0;
        end else if (active) begin
            int s;
            k++;
            for (int c = 0; c < NCH; c++) begin
                s = $signed(sample_bus[c*SW +: SW]);
                hist[c][k] = (k - 1 >= thr_m[c]) ? s : 0;
            end
            exp_out = 0;
            for (int c = 0; c < NCH; c++) begin
                if (k - dep_m[c] >= 1) exp_out += hist[c][k - dep_m[c]];
            end
            exp_valid = (k >= tlim + 1) && (k <= tlim + LLEN);
            if (k > tlim + LLEN) active = 0;
        end else begin
            exp_valid = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            int got;
            checks++;
            if (beam_valid !== exp_valid) begin
                errors++;
                $display("FAIL %s beam_valid got %0b expected %0b (k=%0d)", cur_req, beam_valid, exp_valid, k);
            end
            if (exp_valid) begin
                got = $signed(beam_out);
                checks++;
                if (got != exp_out) begin
                    errors++;
                    $display("FAIL %s beam_out got %0d expected %0d (k=%0d)", cur_req, got, exp_out, k);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            errors++;
            $display("FAIL watchdog: run did not end in time");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic new_samples();
        for (int c = 0; c < NCH; c++) begin
            case (pat_mode)
                1:       sample_bus[c*SW +: SW] = 8'h80;
                2:       sample_bus[c*SW +: SW] = 8'h7F;
                default: sample_bus[c*SW +: SW] = 8'($urandom);
            endcase
        end
    endtask

    task automatic drive_cycle(input bit ls);
        @(negedge clk);
        if (ls) begin
            for (int c = 0; c < NCH; c++) begin
                thr_bus[c*CNTW +: CNTW] = CNTW'(cfg_t[c]);
                depth_bus[c*DW +: DW]   = DW'(cfg_d[c]);
            end
        end
        line_start = ls;
        new_samples();
    endtask

    task automatic run_line(input int tl, input int extra);
        drive_cycle(1);
        repeat (tl + LLEN + extra) drive_cycle(0);
    endtask

    task automatic direct_check(input string req, input int expv);
        int got;
        @(negedge clk);
        got = $signed(beam_out);
        checks++;
        if (got != expv || beam_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s direct sum got %0d/%0b expected %0d/1", req, got, beam_valid, expv);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        checks++;
        if (beam_valid !== 1'b0 || beam_out !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs got %0b/%0h expected 0/0", beam_valid, beam_out);
        end
        @(negedge clk); rst_n = 1'b1;
        chk_en = 1;
        repeat (3) drive_cycle(0);

        // aligned geometry, T = 70
        cur_req = "R2 R3 R4 R6 R7 R8";
        for (int c = 0; c < NCH; c++) begin cfg_t[c] = 10*c; cfg_d[c] = 70 - 10*c; end
        run_line(70, 20);

        // staggered arrivals, zero thresholds and zero depths, T = 301
        cur_req = "R3 R4 R7 R8";
        cfg_t = '{0, 5, 300, 17, 0, 44, 120, 3};
        cfg_d = '{288, 0, 1, 100, 250, 7, 60, 0};
        run_line(301, 20);

        // depths beyond the limit, T = 293
        cur_req = "R5 R7";
        cfg_t = '{0, 1, 2, 3, 4, 5, 6, 7};
        cfg_d = '{400, 511, 289, 288, 0, 300, 1, 2};
        run_line(293, 20);

        // extreme sums
        cur_req = "R6";
        for (int c = 0; c < NCH; c++) begin cfg_t[c] = 10*c; cfg_d[c] = 70 - 10*c; end
        pat_mode = 1;
        drive_cycle(1);
        repeat (3000) drive_cycle(0);
        direct_check("R6 min", -1024);
        pat_mode = 2;
        repeat (200) drive_cycle(0);
        direct_check("R6 max", 1016);
        repeat (3400) drive_cycle(0);
        pat_mode = 0;

        // abort mid-stream, then a start on the final edge
        cur_req = "R2 R9";
        for (int c = 0; c < NCH; c++) begin cfg_t[c] = 0; cfg_d[c] = 5; end
        drive_cycle(1);
        repeat (200) drive_cycle(0);
        for (int c = 0; c < NCH; c++) begin cfg_t[c] = c; cfg_d[c] = 20; end
        drive_cycle(1);
        repeat (27 + LLEN) drive_cycle(0);
        for (int c = 0; c < NCH; c++) begin cfg_t[c] = 2; cfg_d[c] = c; end
        run_line(9, 20);

        chk_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule